// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a system watchdog for a processor subsystem. Software sets a timeout through a control register, which holds a prescaler divide code and a 12-bit reload value. It then writes a restart register at regular intervals to show that it is still running. The block counts down on prescaler ticks. If software fails to restart it in time, the counter expires. On expiry the block can drive a one-cycle system reset request and an interrupt pulse whose length software chooses. After expiry the counter stays at zero until the next restart.

Every register write over the APB slave port carries a 12-bit key in the top bits of the write data. A write whose key does not match the key fixed for the target register is dropped. A stray or runaway store therefore cannot reprogram the watchdog or restart it. A debug halt input freezes the prescaler and the counter.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, irq_o and sysrst_o are low. The zero-mode register at address 0x0 reads 0x00000000. The control register at address 0x4 reads 0x00003FFC, which is divide code 0 and reload 0xFFF.
- R2: A write whose bits [31:20] differ from the register's key changes nothing. The keys are 0xABC for zero-mode (0x0), 0x248 for control (0x4) and 0x199 for restart (0x8). A restart write with a wrong key does not move the pending expiry.
- R3: pready is always 1 and pslverr is always 0. A read returns the register contents with bits [31:20] read as zero.
- R4: The zero-mode register has the watchdog enable at bit 0, the interrupt enable at bit 1 and the interrupt-length code at bits [3:2]. The control register has the divide code at bits [1:0] and the reload value at bits [13:2]. With the watchdog enabled, sysrst_o first reads high exactly F*D clock cycles after the restart write's access edge. F is the reload value placed in the top 12 counter bits with all lower bits set to one. D is the prescaler division.
- R5: Divide codes 0, 1, 2 and 3 give D = 8, 64, 512 and 4096.
- R6: Each expiry makes sysrst_o high for exactly one clock cycle.
- R7: On expiry, irq_o goes high in the same cycle as sysrst_o, but only when the interrupt enable is also set. It stays high for 4, 8, 16 or 32 cycles for length codes 0, 1, 2 and 3. With the interrupt enable clear, irq_o stays low.
- R8: After expiry the counter holds at zero and produces no further pulse until a restart. A later restart begins a full new timeout.
- R9: While halt is high, counting is frozen. Each halted cycle delays expiry by one cycle.
- R10: A keyed restart whose access edge coincides with the expiring tick wins. No pulse is produced, and a full new timeout begins from that edge.
- R11: With the watchdog enable clear, the counter does not advance and neither output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data, key in [31:20] |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| halt | input | 1 | Debug halt, freezes counting |
| irq_o | output | 1 | Expiry interrupt pulse |
| sysrst_o | output | 1 | One-cycle system reset request |

## Verification
The case of interest is a keyed restart landing on the same clock edge as the tick that would bring the counter from one to zero. The bench times a second restart write so that its access edge lands exactly one full timeout after the first. It then judges the outcome at the ports: the reset-pulse count must not change, and the next expiry must arrive exactly one full timeout after the colliding write. A halt window overlapping the count and a wrong-key restart midway through a timeout are also judged by exact expiry timing.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam int DATA_W  = 32;
    localparam int KEY_W   = 12;
    localparam int KEY_LSB = DATA_W - KEY_W;
    localparam int RLD_W   = 12;
    localparam int PRE_W   = 12;
    localparam int IRQ_W   = 6;

    localparam logic [KEY_W-1:0] KEY_ZMODE   = 12'hABC;
    localparam logic [KEY_W-1:0] KEY_CTRL    = 12'h248;
    localparam logic [KEY_W-1:0] KEY_RESTART = 12'h199;

    typedef enum logic [1:0] {
        REG_ZMODE   = 2'd0,
        REG_CTRL    = 2'd1,
        REG_RESTART = 2'd2,
        REG_NONE    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        DIV8    = 2'd0,
        DIV64   = 2'd1,
        DIV512  = 2'd2,
        DIV4096 = 2'd3
    } presc_e;

    typedef struct packed {
        logic [1:0] irq_len;
        logic       irq_en;
        logic       wd_en;
    } zmode_t;

    typedef struct packed {
        logic [RLD_W-1:0] reload;
        presc_e           div;
    } ctrl_t;

    localparam zmode_t ZMODE_RST = '{irq_len: 2'd0, irq_en: 1'b0, wd_en: 1'b0};
    localparam ctrl_t  CTRL_RST  = '{reload: '1, div: DIV8};

    function automatic logic [PRE_W-1:0] presc_last(presc_e d);
        logic [PRE_W:0] full;
        full = (PRE_W+1)'(8) << (3 * int'(d));
        return PRE_W'(full - 1'b1);
    endfunction

    function automatic logic [IRQ_W-1:0] irq_cycles(logic [1:0] code);
        return IRQ_W'(4) << code;
    endfunction

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output zmode_t            zmode,
    output ctrl_t             ctrl,
    output logic              restart
);

    localparam int ZM_W = $bits(zmode_t);
    localparam int CT_W = $bits(ctrl_t);

    reg_sel_e         sel;
    logic             wr_acc;
    logic [KEY_W-1:0] key;
    logic             unused_mid;

    always_comb begin
        unique case (paddr)
            ADDR_W'(0): sel = REG_ZMODE;
            ADDR_W'(4): sel = REG_CTRL;
            ADDR_W'(8): sel = REG_RESTART;
            default:    sel = REG_NONE;
        endcase
    end

    assign wr_acc     = psel && penable && pwrite;
    assign key        = pwdata[KEY_LSB +: KEY_W];
    assign unused_mid = ^pwdata[KEY_LSB-1:CT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            zmode <= ZMODE_RST;
            ctrl  <= CTRL_RST;
        end else if (wr_acc) begin
            if (sel == REG_ZMODE && key == KEY_ZMODE)
                zmode <= zmode_t'(pwdata[ZM_W-1:0]);
            if (sel == REG_CTRL && key == KEY_CTRL)
                ctrl <= ctrl_t'(pwdata[CT_W-1:0]);
        end
    end

    assign restart = wr_acc && (sel == REG_RESTART) && (key == KEY_RESTART);

    always_comb begin
        prdata = '0;
        case (sel)
            REG_ZMODE: prdata[ZM_W-1:0] = zmode;
            REG_CTRL:  prdata[CT_W-1:0] = ctrl;
            default:   prdata = '0;
        endcase
    end

endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler
    import wdk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  presc_e div,
    input  logic   restart,
    input  logic   run,
    output logic   tick
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;

    assign last = presc_last(div);
    assign tick = run && !restart && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= presc_last(DIV8);
        else if (restart)
            cnt_q <= last;
        else if (run)
            cnt_q <= (cnt_q == '0) ? last : cnt_q - 1'b1;
    end

endmodule

// File: rtl/wdk_downcnt.sv
module wdk_downcnt
    import wdk_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [RLD_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    localparam int LOW_W = CNT_W - RLD_W;

    logic [CNT_W-1:0] full;

    generate
        if (LOW_W > 0) begin : g_pad
            assign full = {reload, {LOW_W{1'b1}}};
        end else begin : g_trunc
            assign full = reload[RLD_W-1 -: CNT_W];
        end
    endgenerate

    assign expire = tick && !restart && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '1;
        else if (restart)
            cnt_q <= full;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/wdk_alarm.sv
module wdk_alarm
    import wdk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expire,
    input  zmode_t zmode,
    output logic   irq_o,
    output logic   sysrst_o
);

    logic [IRQ_W-1:0] irq_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_left <= '0;
            sysrst_o <= 1'b0;
        end else begin
            sysrst_o <= expire && zmode.wd_en;
            if (expire && zmode.wd_en && zmode.irq_en)
                irq_left <= irq_cycles(zmode.irq_len);
            else if (irq_left != '0)
                irq_left <= irq_left - 1'b1;
        end
    end

    assign irq_o = (irq_left != '0);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdk_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              halt,
    output logic              irq_o,
    output logic              sysrst_o
);

    zmode_t           zmode;
    ctrl_t            ctrl;
    logic             restart;
    logic             run;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign run     = zmode.wd_en && !halt;

    wdk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .zmode(zmode), .ctrl(ctrl), .restart(restart)
    );

    wdk_prescaler u_pre (
        .clk(clk), .rst(rst), .div(ctrl.div), .restart(restart),
        .run(run), .tick(tick)
    );

    wdk_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .restart(restart), .tick(tick),
        .reload(ctrl.reload), .cnt_q(cnt_q), .expire(expire)
    );

    wdk_alarm u_alarm (
        .clk(clk), .rst(rst), .expire(expire), .zmode(zmode),
        .irq_o(irq_o), .sysrst_o(sysrst_o)
    );

endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             pready,
    input logic             pslverr,
    input logic             halt,
    input logic             restart,
    input logic             wd_en,
    input logic             irq_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic             irq_o,
    input logic             sysrst_o
);

    AST_NO_WAIT_STATE: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);                                          // R3

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sysrst_o |=> !sysrst_o);                                      // R6

    AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (wd_en && irq_en && sysrst_o));              // R7

    AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && !restart) |=> (cnt_q == '0));                // R8

    AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (halt && !restart) |=> $stable(cnt_q));                       // R9

    AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !sysrst_o);                                       // R10

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!wd_en && !restart) |=> $stable(cnt_q));                     // R11

endmodule

bind keyed_wdog wdk_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .pready(pready), .pslverr(pslverr), .halt(halt),
    .restart(restart), .wd_en(zmode.wd_en), .irq_en(zmode.irq_en),
    .cnt_q(cnt_q), .irq_o(irq_o), .sysrst_o(sysrst_o)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;

    localparam int CNT_W = 16;
    localparam int LOW_W = CNT_W - 12;
    localparam int LIMIT = 70000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, halt = 1'b0, irq_o, sysrst_o;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    keyed_wdog #(.CNT_W(CNT_W), .ADDR_W(4)) dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .halt(halt), .irq_o(irq_o), .sysrst_o(sysrst_o)
    );

    always @(negedge clk) if (sysrst_o) pulses++;

    function automatic int exp_timeout(int div_code, int reload);
        return ((reload << LOW_W) | ((1 << LOW_W) - 1)) * (8 << (3 * div_code));
    endfunction

    function automatic int exp_irq(int len, int ien);
        return ien ? (4 << len) : 0;
    endfunction

    function automatic logic [31:0] zm_word(int len, int ien, int en);
        return {12'hABC, 16'h0, 2'(len), 1'(ien), 1'(en)};
    endfunction

    function automatic logic [31:0] ct_word(int div_code, int reload);
        return {12'h248, 6'h0, 12'(reload), 2'(div_code)};
    endfunction

    localparam logic [31:0] RESTART_W = {12'h199, 20'h0};

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // called at a negedge; write edge is 1.5 cycles later; returns at next negedge
    task automatic apb_write(logic [3:0] a, logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(logic [3:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        check("R3 pready", pready, 1);
        check("R3 pslverr", pslverr, 0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_expiry(output int cyc);
        cyc = 0;
        while (!sysrst_o && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic judge_pulse(string tag, int len_exp);
        int n;
        n = irq_o ? 1 : 0;
        @(negedge clk);
        check({"R6 one-cycle reset ", tag}, sysrst_o, 0);
        while (irq_o && n < 64) begin
            n++;
            @(negedge clk);
        end
        check({"R7 irq length ", tag}, n, len_exp);
    endtask

    task automatic run_timeout(string tag, int dc, int rl, int len, int ien);
        int cyc;
        apb_write(4'h4, ct_word(dc, rl));
        apb_write(4'h0, zm_word(len, ien, 1));
        apb_write(4'h8, RESTART_W);
        wait_expiry(cyc);
        check({"R4/R5 timeout ", tag}, cyc, exp_timeout(dc, rl));
        judge_pulse(tag, exp_irq(len, ien));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int cyc, p0, t;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_o", irq_o, 0);
        check("R1 sysrst_o", sysrst_o, 0);
        apb_read(4'h0, rd); check("R1 zmode reset", rd, 32'h0);
        apb_read(4'h4, rd); check("R1 ctrl reset", rd, 32'h00003FFC);

        // R2 wrong keys
        apb_write(4'h4, {12'h247, 6'h0, 12'h5, 2'd1});
        apb_read(4'h4, rd); check("R2 ctrl bad key", rd, 32'h00003FFC);
        apb_write(4'h0, {12'hABD, 16'h0, 4'hF});
        apb_read(4'h0, rd); check("R2 zmode bad key", rd, 32'h0);

        // R3 key field reads zero
        apb_write(4'h4, ct_word(1, 12'hA5));
        apb_read(4'h4, rd); check("R3 ctrl readback", rd, {20'h0, 10'hA5 << 2 >> 2, 2'd1} & 32'hFFFFF | ((32'hA5 << 2) | 32'd1));

        // R11 disabled: restart then long idle, no pulses
        apb_write(4'h4, ct_word(0, 0));
        apb_write(4'h8, RESTART_W);
        p0 = pulses;
        repeat (3 * exp_timeout(0, 0)) @(negedge clk);
        check("R11 no pulse when disabled", pulses - p0, 0);
        check("R11 irq low", irq_o, 0);

        // R4/R5/R7 directed
        run_timeout("div8", 0, 0, 0, 1);
        run_timeout("div512", 2, 0, 3, 1);
        run_timeout("div4096", 3, 0, 1, 1);
        run_timeout("irq off", 0, 1, 2, 0);

        // R8 holds at zero, then restart gives full timeout
        p0 = pulses;
        repeat (4 * exp_timeout(0, 1)) @(negedge clk);
        check("R8 no repeat pulse", pulses - p0, 0);
        apb_write(4'h8, RESTART_W);
        wait_expiry(cyc);
        check("R8 restart after hold", cyc, exp_timeout(0, 1));
        judge_pulse("after hold", 0);

        // R2 wrong-key restart midway does not move expiry
        apb_write(4'h4, ct_word(1, 0));
        apb_write(4'h0, zm_word(0, 1, 1));
        apb_write(4'h8, RESTART_W);
        t = exp_timeout(1, 0);
        repeat (100) @(negedge clk);
        apb_write(4'h8, {12'h198, 20'h0});
        wait_expiry(cyc);
        check("R2 bad restart ignored", cyc + 102, t);
        judge_pulse("bad restart", 4);

        // R9 halt extends by halted cycles
        apb_write(4'h4, ct_word(0, 1));
        apb_write(4'h8, RESTART_W);
        repeat (10) @(negedge clk);
        halt = 1'b1;
        repeat (50) @(negedge clk);
        halt = 1'b0;
        wait_expiry(cyc);
        check("R9 halt delay", cyc + 60, exp_timeout(0, 1) + 50);
        judge_pulse("halt", 4);

        // R10 restart on the expiring edge
        t = exp_timeout(0, 0);
        apb_write(4'h4, ct_word(0, 0));
        apb_write(4'h8, RESTART_W);
        repeat (t - 2) @(negedge clk);
        p0 = pulses;
        apb_write(4'h8, RESTART_W);
        check("R10 collision no pulse", pulses - p0, 0);
        wait_expiry(cyc);
        check("R10 fresh timeout", cyc, t);
        judge_pulse("collision", 4);

        // constrained random
        for (int i = 0; i < 8; i++) begin
            int dc, rl, len, ien;
            dc  = int'($urandom_range(1, 0));
            rl  = int'($urandom_range(3, 0));
            len = int'($urandom_range(3, 0));
            ien = int'($urandom_range(1, 0));
            run_timeout($sformatf("rand%0d", i), dc, rl, len, ien);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule